// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block chooses where each of the two register operands of the instruction in decode comes from, in a five-stage in-order pipeline. Each source register index is compared with the destination index and write enable of the instruction now in execute and of the instruction now in the memory stage. From that comparison the block forms a 2-bit select code for each operand and steers a multiplexer. The multiplexer picks one of three values: the register-file read value, the execute-stage ALU result, or the memory-stage result, which is either an ALU value or load data.

The resolution happens during decode, ahead of the decode/execute boundary. The selected values are latched into the execute-side operand registers on the rising clock edge. The select codes are also driven out combinationally for the pipeline's own use. Stalling after a load, the register file and the ALU sit outside this block. Register-file write-then-read in the same cycle is assumed to return the new value, so a third, older producer needs no bypass path.

Top module: `dec_fwd_unit`

## Requirements
- R1: A source index that is nonzero, equals the execute-stage destination, and has the execute write enable high gets code 01. Its operand register then captures the execute ALU result at the next rising edge.
- R2: A source index that is nonzero and equals the memory-stage destination, with the memory write enable high, gets code 10 when it has no execute-stage match. Its operand register then captures the memory-stage result.
- R3: A source with neither match gets code 00, and its operand register captures the register-file read value for that source.
- R4: When a source matches both stages, the execute stage wins and the code is 01.
- R5: Source index 0 never matches, even when a destination is 0 with its write enable high. The code is 00.
- R6: A destination whose write enable is low never matches, whatever its index.
- R7: The two operands (first source, second source) have independent select codes and operand registers, and each uses the same matching rule.
- R8: While rst_ni is low, both operand registers read 0.
- R9: Code 11 is never produced. A multiplexer that sees code 11 passes the register-file value.
- R10: Consider a load to register 4 in the memory stage and an add writing register 7 in execute. A decode of first source 4 and second source 7 yields first-source code 10 and second-source code 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rs_idx_i | input | IDX_W | First source index of the decoding instruction |
| rt_idx_i | input | IDX_W | Second source index of the decoding instruction |
| ex_dst_i | input | IDX_W | Destination index of the instruction in execute |
| ex_wen_i | input | 1 | Register write enable of the instruction in execute |
| mem_dst_i | input | IDX_W | Destination index of the instruction in memory stage |
| mem_wen_i | input | 1 | Register write enable of the instruction in memory stage |
| rf_rs_data_i | input | DATA_W | Register-file read value for first source |
| rf_rt_data_i | input | DATA_W | Register-file read value for second source |
| ex_alu_i | input | DATA_W | ALU output of the instruction in execute |
| mem_res_i | input | DATA_W | Result held in the memory stage (ALU value or load data) |
| sel_rs_o | output | 2 | Select code for first source |
| sel_rt_o | output | 2 | Select code for second source |
| opnd_rs_o | output | DATA_W | Latched first operand for execute |
| opnd_rt_o | output | DATA_W | Latched second operand for execute |

## Verification
The assertions take for granted that all data and index inputs are settled and stable across each rising edge, and that the operand registers are judged one cycle after the inputs they sampled. The stimulus changes inputs only on the falling edge. It draws indices from a small range (0 to 3), so that double matches, index-zero destinations and disabled writes occur often. A behavioural model in the bench predicts both the codes and the latched operands for every cycle.

// File: rtl/dec_fwd_pkg.sv
package dec_fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_EX  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/dec_fwd_match.sv
module dec_fwd_match
  import dec_fwd_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] src_idx_i,
  input  logic [IDX_W-1:0] ex_dst_i,
  input  logic             ex_wen_i,
  input  logic [IDX_W-1:0] mem_dst_i,
  input  logic             mem_wen_i,
  output logic [1:0]       sel_o
);
  logic src_live, hit_ex, hit_mem;

  assign src_live = |src_idx_i;
  assign hit_ex   = src_live && ex_wen_i  && (src_idx_i == ex_dst_i);
  assign hit_mem  = src_live && mem_wen_i && (src_idx_i == mem_dst_i);

  // nearer producer first
  always_comb begin
    if (hit_ex)       sel_o = FWD_EX;
    else if (hit_mem) sel_o = FWD_MEM;
    else              sel_o = FWD_RF;
  end
endmodule

// File: rtl/dec_fwd_mux.sv
module dec_fwd_mux
  import dec_fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] rf_i,
  input  logic [DATA_W-1:0] ex_i,
  input  logic [DATA_W-1:0] mem_i,
  output logic [DATA_W-1:0] val_o
);
  always_comb begin
    case (sel_i)
      FWD_EX:  val_o = ex_i;
      FWD_MEM: val_o = mem_i;
      default: val_o = rf_i;  // 00 and unused 11
    endcase
  end
endmodule

// File: rtl/dec_fwd_opreg.sv
module dec_fwd_opreg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/dec_fwd_unit.sv
module dec_fwd_unit
  import dec_fwd_pkg::*;
#(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rs_idx_i,
  input  logic [IDX_W-1:0]  rt_idx_i,
  input  logic [IDX_W-1:0]  ex_dst_i,
  input  logic              ex_wen_i,
  input  logic [IDX_W-1:0]  mem_dst_i,
  input  logic              mem_wen_i,
  input  logic [DATA_W-1:0] rf_rs_data_i,
  input  logic [DATA_W-1:0] rf_rt_data_i,
  input  logic [DATA_W-1:0] ex_alu_i,
  input  logic [DATA_W-1:0] mem_res_i,
  output logic [1:0]        sel_rs_o,
  output logic [1:0]        sel_rt_o,
  output logic [DATA_W-1:0] opnd_rs_o,
  output logic [DATA_W-1:0] opnd_rt_o
);
  logic [IDX_W-1:0]  src_idx [NUM_SRC];
  logic [DATA_W-1:0] rf_val  [NUM_SRC];
  logic [1:0]        sel     [NUM_SRC];
  logic [DATA_W-1:0] pick    [NUM_SRC];
  logic [DATA_W-1:0] opnd    [NUM_SRC];

  assign src_idx[0] = rs_idx_i;
  assign src_idx[1] = rt_idx_i;
  assign rf_val[0]  = rf_rs_data_i;
  assign rf_val[1]  = rf_rt_data_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    dec_fwd_match #(.IDX_W(IDX_W)) u_match (
      .src_idx_i (src_idx[g]),
      .ex_dst_i  (ex_dst_i),
      .ex_wen_i  (ex_wen_i),
      .mem_dst_i (mem_dst_i),
      .mem_wen_i (mem_wen_i),
      .sel_o     (sel[g])
    );
    dec_fwd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel_i (sel[g]),
      .rf_i  (rf_val[g]),
      .ex_i  (ex_alu_i),
      .mem_i (mem_res_i),
      .val_o (pick[g])
    );
    dec_fwd_opreg #(.DATA_W(DATA_W)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pick[g]),
      .q_o    (opnd[g])
    );
  end

  assign sel_rs_o  = sel[0];
  assign sel_rt_o  = sel[1];
  assign opnd_rs_o = opnd[0];
  assign opnd_rt_o = opnd[1];
endmodule

// File: rtl/dec_fwd_chk.sv
module dec_fwd_chk #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IDX_W-1:0]  rs_idx_i,
  input logic [IDX_W-1:0]  rt_idx_i,
  input logic [IDX_W-1:0]  ex_dst_i,
  input logic              ex_wen_i,
  input logic [IDX_W-1:0]  mem_dst_i,
  input logic              mem_wen_i,
  input logic [DATA_W-1:0] rf_rs_data_i,
  input logic [DATA_W-1:0] rf_rt_data_i,
  input logic [DATA_W-1:0] ex_alu_i,
  input logic [DATA_W-1:0] mem_res_i,
  input logic [1:0]        sel_rs_o,
  input logic [1:0]        sel_rt_o,
  input logic [DATA_W-1:0] opnd_rs_o,
  input logic [DATA_W-1:0] opnd_rt_o
);
  // R1 and R4: execute match latches ALU result regardless of memory match
  a_r1_ex_bypass_rs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_idx_i != '0 && ex_wen_i && rs_idx_i == ex_dst_i)
      |=> opnd_rs_o == $past(ex_alu_i));
  a_r4_ex_wins_rt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_idx_i != '0 && ex_wen_i && rt_idx_i == ex_dst_i && mem_wen_i && rt_idx_i == mem_dst_i)
      |=> opnd_rt_o == $past(ex_alu_i));
  // R2
  a_r2_mem_bypass_rs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_idx_i != '0 && mem_wen_i && rs_idx_i == mem_dst_i && !(ex_wen_i && rs_idx_i == ex_dst_i))
      |=> opnd_rs_o == $past(mem_res_i));
  // R5
  a_r5_zero_src_rs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_idx_i == '0) |=> opnd_rs_o == $past(rf_rs_data_i));
  // R6
  a_r6_no_wen_rt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ex_wen_i && !mem_wen_i) |=> opnd_rt_o == $past(rf_rt_data_i));
  // R9
  a_r9_no_code3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rs_o != 2'b11 && sel_rt_o != 2'b11);
endmodule

bind dec_fwd_unit dec_fwd_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dec_fwd_unit_tb.sv
module dec_fwd_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W  = 5;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [IDX_W-1:0]  rs_idx = '0, rt_idx = '0, ex_dst = '0, mem_dst = '0;
  logic              ex_wen = 1'b0, mem_wen = 1'b0;
  logic [DATA_W-1:0] rf_rs = '0, rf_rt = '0, ex_alu = '0, mem_res = '0;
  logic [1:0]        sel_rs, sel_rt;
  logic [DATA_W-1:0] opnd_rs, opnd_rt;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [DATA_W-1:0] exp_rs = '0, exp_rt = '0;
  bit have_exp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_fwd_unit #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rs_idx_i(rs_idx), .rt_idx_i(rt_idx),
    .ex_dst_i(ex_dst), .ex_wen_i(ex_wen),
    .mem_dst_i(mem_dst), .mem_wen_i(mem_wen),
    .rf_rs_data_i(rf_rs), .rf_rt_data_i(rf_rt),
    .ex_alu_i(ex_alu), .mem_res_i(mem_res),
    .sel_rs_o(sel_rs), .sel_rt_o(sel_rt),
    .opnd_rs_o(opnd_rs), .opnd_rt_o(opnd_rt)
  );

  function automatic int ref_code(int src, int exd, bit exw, int memd, bit memw);
    if (src == 0) return 0;
    if (exw && exd == src) return 1;
    if (memw && memd == src) return 2;
    return 0;
  endfunction

  function automatic logic [DATA_W-1:0] ref_val(int code, logic [DATA_W-1:0] rf);
    if (code == 1) return ex_alu;
    if (code == 2) return mem_res;
    return rf;
  endfunction

  task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive one decode cycle at the falling edge, check codes and previous latch
  task automatic step(int rs, int rt, int exd, bit exw, int memd, bit memw, string req);
    @(negedge clk);
    if (have_exp) begin
      chk({req, " R7 opnd_rs"}, opnd_rs, exp_rs);
      chk({req, " R7 opnd_rt"}, opnd_rt, exp_rt);
    end
    rs_idx = IDX_W'(rs); rt_idx = IDX_W'(rt);
    ex_dst = IDX_W'(exd); ex_wen = exw;
    mem_dst = IDX_W'(memd); mem_wen = memw;
    rf_rs = $urandom; rf_rt = $urandom; ex_alu = $urandom; mem_res = $urandom;
    #1;
    begin
      int ca, cb;
      ca = ref_code(rs, exd, exw, memd, memw);
      cb = ref_code(rt, exd, exw, memd, memw);
      chk({req, " sel_rs"}, DATA_W'(sel_rs), DATA_W'(ca));
      chk({req, " sel_rt"}, DATA_W'(sel_rt), DATA_W'(cb));
      if (sel_rs == 2'b11 || sel_rt == 2'b11) chk("R9 code3", 1, 0);
      exp_rs = ref_val(ca, rf_rs);
      exp_rt = ref_val(cb, rf_rt);
      have_exp = 1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R8: reset holds operand registers at 0
    rf_rs = 32'hdead_beef; rf_rt = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 opnd_rs in reset", opnd_rs, '0);
    chk("R8 opnd_rt in reset", opnd_rt, '0);
    rst_ni = 1'b1;

    step(3, 5, 3, 1, 9, 1, "R1");          // rs from execute
    step(6, 9, 3, 1, 9, 1, "R2");          // rt from memory stage
    step(11, 12, 3, 1, 9, 1, "R3");        // no match
    step(8, 8, 8, 1, 8, 1, "R4");          // both match, execute wins
    step(0, 0, 0, 1, 0, 1, "R5");          // index zero never forwards
    step(0, 4, 0, 1, 4, 1, "R5");
    step(7, 7, 7, 0, 7, 0, "R6");          // write enables low
    step(7, 7, 7, 0, 7, 1, "R6");          // only memory stage enabled
    // R10: lw r4 in memory stage, add r7 in execute, sub decodes 4 and 7
    step(9, 0, 0, 0, 0, 0, "R10 lw");
    step(5, 6, 4, 1, 0, 0, "R10 add");
    step(4, 7, 7, 1, 4, 1, "R10 sub");
    chk("R10 sel_rs", DATA_W'(sel_rs), DATA_W'(2));
    chk("R10 sel_rt", DATA_W'(sel_rt), DATA_W'(1));

    for (int i = 0; i < 400; i++) begin
      step($urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 3), 1'($urandom_range(0, 1)),
           $urandom_range(0, 3), 1'($urandom_range(0, 1)), "R7 rand");
    end
    step(0, 0, 0, 0, 0, 0, "R3 drain");

    // R8: asynchronous reset clears latched operands
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R8 opnd_rs async", opnd_rs, '0);
    chk("R8 opnd_rt async", opnd_rt, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule